// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block is the device-side controller of a receive queue. Software keeps a circular ring of 16-byte descriptors in host memory. Each slot starts out as a record that names a free packet buffer. It hands slots to the device by moving a head index. For every arriving packet the engine checks that a free slot exists and reads the buffer address from that slot. It streams the payload into the buffer, 8 bytes per beat. It then overwrites the same slot in place with a status record that carries a done flag, so software can see progress by polling memory.

A slot counts as free only while the software head index differs from the engine's own index. When they are equal, the packet is consumed from the input and discarded, and a drop counter is incremented. The engine's index wraps to 0 after the last slot of the ring. Memory is reached through a read port with a fixed one-cycle latency and through a write port of one 64-bit word per cycle.

Top module: `rx_ring_wb_engine`

## Requirements
- R1: After reset, hw_idx is 0, drop_count is 0, the head index is 0, in_ready is low and neither memory port is active.
- R2: A configuration write selects a register with cfg_sel. The value 0 sets the ring base address and 1 sets the ring length in descriptors. Writing the length also returns hw_idx to 0. The value 2 sets the software head index, and the value 3 has no effect.
- R3: If the head index equals hw_idx when a packet's first beat is presented, every beat of that packet is accepted and nothing is written to memory. drop_count then rises by exactly 1 in the cycle after the last beat is accepted.
- R4: A packet that finds a free slot causes one read of the address base + 16*hw_idx. The low AW bits of the data returned one cycle later are kept as the buffer address.
- R5: Payload beat k (counting from 0) is written to buffer address + 8*k, one write per accepted beat.
- R6: After the last beat, the first descriptor word at base + 16*hw_idx is rewritten. Its bits 15:0 hold in_ctx, bits 31:16 hold in_tag and bits 63:32 hold in_hash, all taken with the last beat.
- R7: The second descriptor word at base + 16*hw_idx + 8 is then rewritten. Bit 0 is done (1), bit 1 is end of packet (1), bit 19 is in_csum_bad, bits 37:30 hold in_ptype and bits 52:38 hold in_len. All other bits are 0.
- R8: The two descriptor writes take consecutive cycles, starting the cycle after the last payload beat. hw_idx changes only at the end of the second write (or on a length write).
- R9: hw_idx advances by one per written-back descriptor and wraps from ring length - 1 to 0.
- R10: The free test uses the head value held before the cycle in which the packet's first beat is first seen. A head write in that same cycle takes effect from the next packet.
- R11: The read and write ports are never active in the same cycle. in_ready is high only while payload or dropped beats are being taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 length, 2 head |
| cfg_wdata | input | AW | Configuration write value |
| in_valid | input | 1 | Packet beat valid |
| in_ready | output | 1 | Packet beat accepted when high with in_valid |
| in_data | input | 64 | Payload beat |
| in_last | input | 1 | Final beat of the packet |
| in_len | input | 15 | Packet length in bytes, taken with the last beat |
| in_ptype | input | 8 | Packet type code, taken with the last beat |
| in_csum_bad | input | 1 | Checksum check failed, taken with the last beat |
| in_tag | input | 16 | Stripped layer-2 tag, taken with the last beat |
| in_ctx | input | 16 | Mirroring/context value, taken with the last beat |
| in_hash | input | 32 | Hash or filter identifier, taken with the last beat |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read byte address |
| mem_rd_data | input | 64 | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write byte address |
| mem_wr_data | output | 64 | Memory write data |
| hw_idx | output | IDX_W | Engine ring index |
| drop_count | output | 32 | Count of packets dropped for lack of a free slot |

## Verification
Two actions can land in the same cycle: software moving the head index, and the engine deciding whether a newly presented packet has a free slot. The bench drives a head write together with the first beat of a packet while the ring is full. The reference model expects that packet to be dropped under the old head and the next packet to be accepted under the new one. A length rewrite is likewise placed right after traffic to confirm that the index restarts at 0 before the next fetch.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DATA,
        ST_DROP,
        ST_WB0,
        ST_WB1
    } eng_state_e;

    localparam int unsigned LEN_W        = 15;
    localparam int unsigned DONE_POS     = 0;
    localparam int unsigned EOP_POS      = 1;
    localparam int unsigned CSUM_ERR_POS = 19;
    localparam int unsigned PTYPE_LSB    = 30;
    localparam int unsigned LEN_LSB      = 38;

    typedef struct packed {
        logic [31:0]      hash;
        logic [15:0]      tag;
        logic [15:0]      ctx;
        logic [7:0]       ptype;
        logic [LEN_W-1:0] len;
        logic             csum_bad;
    } rx_meta_t;

    function automatic logic [63:0] fmt_word0(rx_meta_t m);
        return {m.hash, m.tag, m.ctx};
    endfunction

    function automatic logic [63:0] fmt_word1(rx_meta_t m);
        logic [63:0] w;
        w = '0;
        w[DONE_POS]                    = 1'b1;
        w[EOP_POS]                     = 1'b1;
        w[CSUM_ERR_POS]                = m.csum_bad;
        w[PTYPE_LSB +: 8]              = m.ptype;
        w[LEN_LSB +: LEN_W]            = m.len;
        return w;
    endfunction

endpackage

// File: rtl/rx_ring_cfg_regs.sv
module rx_ring_cfg_regs #(
    parameter int AW    = 32,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    ring_base,
    output logic [IDX_W:0]   ring_len,
    output logic [IDX_W-1:0] ring_head,
    output logic             len_wr
);
    typedef struct packed {
        logic [AW-1:0]    base;
        logic [IDX_W:0]   len;
        logic [IDX_W-1:0] head;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    always_comb begin
        cfg_d  = cfg_q;
        len_wr = 1'b0;
        if (cfg_wr) begin
            case (cfg_sel)
                2'd0: cfg_d.base = cfg_wdata;
                2'd1: begin
                    cfg_d.len = cfg_wdata[IDX_W:0];
                    len_wr    = 1'b1;
                end
                2'd2: cfg_d.head = cfg_wdata[IDX_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ring_base = cfg_q.base;
    assign ring_len  = cfg_q.len;
    assign ring_head = cfg_q.head;
endmodule

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
    parameter int AW    = 32,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [AW-1:0]    base,
    input  logic [IDX_W:0]   len,
    input  logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] idx,
    output logic             full,
    output logic [AW-1:0]    desc_addr
);
    localparam int LW         = IDX_W + 1;
    localparam int DESC_SHIFT = 4;

    logic [IDX_W-1:0] idx_q, idx_d;
    logic             at_end;

    always_comb begin
        at_end = ({1'b0, idx_q} == (len - LW'(1)));
        idx_d  = idx_q;
        if (clear)        idx_d = '0;
        else if (advance) idx_d = at_end ? '0 : idx_q + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx       = idx_q;
    assign full      = (head == idx_q);
    assign desc_addr = base + (AW'(idx_q) << DESC_SHIFT);
endmodule

// File: rtl/rx_ring_wb_engine.sv
module rx_ring_wb_engine
    import rx_ring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [63:0]      in_data,
    input  logic             in_last,
    input  logic [14:0]      in_len,
    input  logic [7:0]       in_ptype,
    input  logic             in_csum_bad,
    input  logic [15:0]      in_tag,
    input  logic [15:0]      in_ctx,
    input  logic [31:0]      in_hash,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [63:0]      mem_rd_data,
    output logic             mem_wr_en,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [63:0]      mem_wr_data,
    output logic [IDX_W-1:0] hw_idx,
    output logic [31:0]      drop_count
);
    localparam logic [AW-1:0] BEAT_BYTES = AW'(8);
    localparam logic [AW-1:0] WORD1_OFS  = AW'(8);

    logic [AW-1:0]    ring_base;
    logic [IDX_W:0]   ring_len;
    logic [IDX_W-1:0] ring_head;
    logic             len_wr;
    logic [AW-1:0]    desc_addr;
    logic             ring_full;
    logic             advance;
    logic [63-AW:0]   unused_rd_hi;

    rx_ring_cfg_regs #(.AW(AW), .IDX_W(IDX_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ring_base (ring_base),
        .ring_len  (ring_len),
        .ring_head (ring_head),
        .len_wr    (len_wr)
    );

    rx_ring_ptr #(.AW(AW), .IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (len_wr),
        .advance   (advance),
        .base      (ring_base),
        .len       (ring_len),
        .head      (ring_head),
        .idx       (hw_idx),
        .full      (ring_full),
        .desc_addr (desc_addr)
    );

    typedef struct packed {
        eng_state_e    state;
        logic [AW-1:0] buf_addr;
        logic [AW-1:0] off;
        rx_meta_t      meta;
        logic [31:0]   drops;
    } eng_t;

    eng_t q, d;

    assign unused_rd_hi = mem_rd_data[63:AW];

    always_comb begin
        d           = q;
        in_ready    = 1'b0;
        advance     = 1'b0;
        mem_rd_en   = 1'b0;
        mem_rd_addr = desc_addr;
        mem_wr_en   = 1'b0;
        mem_wr_addr = '0;
        mem_wr_data = '0;
        case (q.state)
            ST_IDLE: begin
                if (in_valid) begin
                    if (ring_full) begin
                        d.state = ST_DROP;
                    end else begin
                        mem_rd_en = 1'b1;
                        d.state   = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                d.buf_addr = mem_rd_data[AW-1:0];
                d.off      = '0;
                d.state    = ST_DATA;
            end
            ST_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    mem_wr_en   = 1'b1;
                    mem_wr_addr = q.buf_addr + q.off;
                    mem_wr_data = in_data;
                    d.off       = q.off + BEAT_BYTES;
                    if (in_last) begin
                        d.meta.hash     = in_hash;
                        d.meta.tag      = in_tag;
                        d.meta.ctx      = in_ctx;
                        d.meta.ptype    = in_ptype;
                        d.meta.len      = in_len;
                        d.meta.csum_bad = in_csum_bad;
                        d.state         = ST_WB0;
                    end
                end
            end
            ST_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) begin
                    d.drops = q.drops + 32'd1;
                    d.state = ST_IDLE;
                end
            end
            ST_WB0: begin
                mem_wr_en   = 1'b1;
                mem_wr_addr = desc_addr;
                mem_wr_data = fmt_word0(q.meta);
                d.state     = ST_WB1;
            end
            ST_WB1: begin
                mem_wr_en   = 1'b1;
                mem_wr_addr = desc_addr + WORD1_OFS;
                mem_wr_data = fmt_word1(q.meta);
                advance     = 1'b1;
                d.state     = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign drop_count = q.drops;
endmodule

// File: rtl/rx_ring_wb_checker.sv
module rx_ring_wb_checker #(
    parameter int AW    = 32,
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic             mem_rd_en,
    input logic             mem_wr_en,
    input logic [AW-1:0]    mem_wr_addr,
    input logic [63:0]      mem_wr_data,
    input logic [IDX_W-1:0] hw_idx,
    input logic [IDX_W:0]   ring_len,
    input logic             len_wr,
    input logic [31:0]      drop_count
);
    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R11

    AST_READ_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !in_ready); // R11

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_len != '0) |-> ({1'b0, hw_idx} < ring_len)); // R9

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 32'd1)); // R3

    AST_DROP_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> $past(in_valid && in_ready && in_last)); // R3

    AST_IDX_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(hw_idx) && !$past(len_wr)) |->
            $past(mem_wr_en && mem_wr_data[0] && mem_wr_addr[3])); // R8
endmodule

bind rx_ring_wb_engine rx_ring_wb_checker #(.AW(AW), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/rx_ring_wb_engine_bench.sv
`timescale 1ns/1ps
module rx_ring_wb_engine_bench;
    localparam int AW    = 32;
    localparam int IDX_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [1:0]       cfg_sel = '0;
    logic [AW-1:0]    cfg_wdata = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [63:0]      in_data = '0;
    logic             in_last = 1'b0;
    logic [14:0]      in_len = '0;
    logic [7:0]       in_ptype = '0;
    logic             in_csum_bad = 1'b0;
    logic [15:0]      in_tag = '0;
    logic [15:0]      in_ctx = '0;
    logic [31:0]      in_hash = '0;
    logic             mem_rd_en;
    logic [AW-1:0]    mem_rd_addr;
    logic [63:0]      mem_rd_data = '0;
    logic             mem_wr_en;
    logic [AW-1:0]    mem_wr_addr;
    logic [63:0]      mem_wr_data;
    logic [IDX_W-1:0] hw_idx;
    logic [31:0]      drop_count;

    rx_ring_wb_engine #(.AW(AW), .IDX_W(IDX_W)) u_rx_ring_wb_engine (.*);

    always #5 clk = ~clk;

    logic [63:0] mem [0:8191];

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[15:3]];
        if (mem_wr_en) mem[mem_wr_addr[15:3]] <= mem_wr_data;
    end

    int n_checks = 0;
    int n_err    = 0;

    // behavioural model state
    int m_idx = 0, m_head = 0, m_len = 0, m_drops = 0;
    logic [31:0] m_base = '0;
    logic [31:0] exp_rd_addr[$];
    logic [31:0] exp_wr_addr[$];
    logic [63:0] exp_wr_data[$];
    string       exp_wr_tag[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-clock comparison of memory traffic against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_en || mem_wr_en)
                chk(!(mem_rd_en && mem_wr_en), "R11", "read and write together",
                    {62'd0, mem_rd_en, mem_wr_en}, 64'd0);
            if (mem_rd_en) begin
                if (exp_rd_addr.size() == 0)
                    chk(1'b0, "R3", "unexpected read", 64'(mem_rd_addr), 64'd0);
                else begin
                    logic [31:0] ea;
                    ea = exp_rd_addr.pop_front();
                    chk(mem_rd_addr == ea, "R4", "fetch address", 64'(mem_rd_addr), 64'(ea));
                end
            end
            if (mem_wr_en) begin
                if (exp_wr_addr.size() == 0)
                    chk(1'b0, "R3", "unexpected write", 64'(mem_wr_addr), 64'd0);
                else begin
                    logic [31:0] ea;
                    logic [63:0] ed;
                    string       et;
                    ea = exp_wr_addr.pop_front();
                    ed = exp_wr_data.pop_front();
                    et = exp_wr_tag.pop_front();
                    chk(mem_wr_addr == ea, et, "write address", 64'(mem_wr_addr), 64'(ea));
                    chk(mem_wr_data == ed, et, "write data", mem_wr_data, ed);
                end
            end
        end
    end

    function automatic logic [63:0] beat_val(int seed, int k);
        return {32'hC0DE0000 | 32'(seed), 32'(k * 3 + 1)};
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        if (sel == 2'd0) m_base = val;
        if (sel == 2'd1) begin m_len = int'(val); m_idx = 0; end
        if (sel == 2'd2) m_head = int'(val);
    endtask

    // software re-arms every slot with a buffer address
    task automatic rearm(input logic [31:0] buf_base);
        for (int i = 0; i < m_len; i++) begin
            logic [31:0] a;
            a = m_base + 32'(i * 16);
            mem[a[15:3]]     = 64'(buf_base + 32'(i * 'h200));
            mem[a[15:3] + 1] = 64'h0;
        end
    endtask

    task automatic send_pkt(input int nb, input int len, input int ptype, input bit csum,
                            input int tag, input int ctx, input int hash, input int seed,
                            input int new_head);
        logic [31:0] desc, bufa;
        logic [63:0] w1;
        bit rdy;
        desc = m_base + 32'(m_idx * 16);
        if (m_head == m_idx) begin
            m_drops++;
        end else begin
            exp_rd_addr.push_back(desc);
            bufa = mem[desc[15:3]][31:0];
            for (int k = 0; k < nb; k++) begin
                exp_wr_addr.push_back(bufa + 32'(8 * k));
                exp_wr_data.push_back(beat_val(seed, k));
                exp_wr_tag.push_back("R5");
            end
            exp_wr_addr.push_back(desc);
            exp_wr_data.push_back({32'(hash), 16'(tag), 16'(ctx)});
            exp_wr_tag.push_back("R6");
            w1 = 64'h3 | (64'(csum) << 19) | (64'(ptype & 'hff) << 30) | (64'(len & 'h7fff) << 38);
            exp_wr_addr.push_back(desc + 32'd8);
            exp_wr_data.push_back(w1);
            exp_wr_tag.push_back("R7");
            m_idx = (m_idx == m_len - 1) ? 0 : m_idx + 1;
        end
        @(posedge clk); #1;
        if (new_head >= 0) begin
            cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'(new_head);
            m_head = new_head;
        end
        for (int k = 0; k < nb; k++) begin
            in_valid = 1'b1; in_data = beat_val(seed, k); in_last = (k == nb - 1);
            in_len = 15'(len); in_ptype = 8'(ptype); in_csum_bad = csum;
            in_tag = 16'(tag); in_ctx = 16'(ctx); in_hash = 32'(hash);
            do begin
                @(negedge clk); rdy = in_ready;
                @(posedge clk); #1;
                cfg_wr = 1'b0;
            end while (!rdy);
        end
        in_valid = 1'b0; in_last = 1'b0;
        repeat (5) @(negedge clk);
        chk(hw_idx == IDX_W'(m_idx), "R9", "ring index", 64'(hw_idx), 64'(m_idx));
        chk(drop_count == 32'(m_drops), "R3", "drop count", 64'(drop_count), 64'(m_drops));
        chk(exp_wr_addr.size() == 0, "R8", "writes outstanding", 64'(exp_wr_addr.size()), 64'd0);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run did not finish", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8192; i++) mem[i] = '0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(hw_idx == '0, "R1", "index after reset", 64'(hw_idx), 64'd0);
        chk(drop_count == '0, "R1", "drops after reset", 64'(drop_count), 64'd0);
        chk(!in_ready && !mem_rd_en && !mem_wr_en, "R1", "idle outputs",
            {61'd0, in_ready, mem_rd_en, mem_wr_en}, 64'd0);

        cfg_write(2'd0, 32'h100);
        cfg_write(2'd1, 32'd4);
        cfg_write(2'd3, 32'd1); // R2: select 3 has no effect
        rearm(32'h1000);
        // R3 / R1: head still 0, so the ring offers nothing
        send_pkt(2, 16, 1, 0, 'h11, 'h21, 'h31, 1, -1);

        cfg_write(2'd2, 32'd3);
        send_pkt(1, 8, 'h05, 0, 'h1234, 'h00aa, 'hdeadbeef, 2, -1);
        send_pkt(3, 23, 'h7f, 1, 'hffff, 'h8001, 'h01020304, 3, -1);
        send_pkt(2, 16, 'hc3, 0, 'h0f0f, 'h5555, 'hcafef00d, 4, -1);
        // R3: index 3 meets head 3
        send_pkt(4, 32, 1, 1, 1, 1, 1, 5, -1);

        // R9: hand back slots 3 and 0, index wraps
        rearm(32'h2000);
        cfg_write(2'd2, 32'd1);
        send_pkt(1, 5, 'h10, 1, 'h0a0a, 'h0b0b, 'h7fffffff, 6, -1);
        chk(hw_idx == '0, "R9", "wrap to zero", 64'(hw_idx), 64'd0);
        send_pkt(2, 12, 'h20, 0, 'h0c0c, 'h0d0d, 'h80000000, 7, -1);

        // R10: ring full, head moved in the same cycle as the first beat
        send_pkt(2, 16, 'h30, 0, 'h1, 'h2, 'h3, 8, 3);
        chk(drop_count == 32'd3, "R10", "same-cycle head write ignored", 64'(drop_count), 64'd3);
        rearm(32'h3000);
        send_pkt(1, 8, 'h31, 1, 'h4, 'h5, 'h6, 9, -1);
        chk(hw_idx == IDX_W'(2), "R10", "next packet accepted", 64'(hw_idx), 64'd2);

        // R2: new length resets the index, new base moves fetches
        cfg_write(2'd1, 32'd6);
        @(negedge clk);
        chk(hw_idx == '0, "R2", "length write clears index", 64'(hw_idx), 64'd0);
        cfg_write(2'd0, 32'h400);
        cfg_write(2'd1, 32'd6);
        rearm(32'h4000);
        cfg_write(2'd2, 32'd5);
        send_pkt(5, 40, 'h44, 0, 'h9999, 'h7777, 'h13572468, 10, -1);
        send_pkt(1, 1, 'h45, 1, 'h8888, 'h6666, 'h24681357, 11, -1);
        chk(mem[13'(32'h418 >> 3)][0] == 1'b1, "R7", "done flag in memory",
            64'(mem[13'(32'h418 >> 3)][0]), 64'd1);

        finish_run();
    end
endmodule